// File: doc/BRIEF.md
# External Data Bus Access Sequencer

This block carries out one read or write to a 64K external data space over a shared bus made of a multiplexed low port and a high address port. A requester offers a transfer with a direction, a pointer kind, a 16-bit address and a write byte. The block then runs a fixed twelve-period transfer. It raises an address-latch strobe once, drives the low address byte and then the write data onto the low port, and pulses an active-low read or write strobe. On a read it returns the byte found on the low port.

The two pointer kinds treat the high port differently. With the wide (16-bit) pointer, the high address byte takes over the high port for the rest of the transfer. A strong-drive enable is raised for the first periods of that override, and once the transfer ends the port goes back to the value in its general-purpose latch. With the narrow (8-bit) pointer, the high port is never touched: it keeps showing its latch, which then acts as the page, and only the low address byte is used. One clock equals one oscillator period. Phase k of a transfer, written Tk, is the k-th clock after the request is accepted.

Top module: `xdata_bus_ctrl`

## Requirements
- R1: A request with `req_valid` high is accepted on a clock edge where `busy` is low. `busy` is then high for exactly twelve clocks (T1..T12) and low on the next clock.
- R2: `ale` is high in T2 and T3 only, one pulse per transfer, and low while idle.
- R3: In T3..T5 `lo_port_oe` is 1 and `lo_port_out` carries address bits [7:0]. On a write, T6..T12 keep `lo_port_oe` at 1 with the write byte on `lo_port_out`.
- R4: On a read, `rd_n` is 0 in T7..T11. `lo_port_in` is sampled at the edge ending T11. `rdata` shows that byte from T12 and holds it afterwards. `rdata_valid` is 1 in T12 of a read only.
- R5: On a write, `wr_n` is 0 in T7..T11. `rd_n` and `wr_n` are never 0 together, and neither is 0 while idle.
- R6: Outside T3..T5, and outside the write data window, `lo_port_out` is all ones (8'hFF) and `lo_port_oe` is 0. This includes the idle state after T12.
- R7: With the wide pointer (`req_wide`=1), `hi_port_out` carries address bits [15:8] in T3..T12 and shows `hi_latch` in T1, T2 and once idle again.
- R8: With the narrow pointer (`req_wide`=0), `hi_port_out` equals `hi_latch` in every cycle, even when `hi_latch` changes mid-transfer. Address bits [15:8] have no effect.
- R9: `hi_strong` is 1 only in T3 and T4 of a wide-pointer transfer (STRONG_PERIODS=2).
- R10: A request offered while `busy` is high is ignored. The running transfer keeps its timing and data, and no second transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one oscillator period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit pointer |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Byte to write |
| hi_latch | input | 8 | General-purpose latch value of the high port |
| lo_port_in | input | 8 | Value read back from the low port pins |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| lo_port_out | output | 8 | Low port output value |
| lo_port_oe | output | 1 | Low port output enable (0 = high impedance) |
| hi_port_out | output | 8 | High port output value |
| hi_strong | output | 1 | High port strong-drive enable |
| busy | output | 1 | Transfer in progress |
| rdata | output | 8 | Byte captured by the last read |
| rdata_valid | output | 1 | Read data valid in T12 |

## Verification
All bus outputs are decoded from the registered phase, so each one is due in the same clock as its phase. Phase Tk begins k edges after the accepting edge. Read data is registered once more: it is due one clock after the edge that ends T11, which is T12. The bench drives the request one falling edge before the accepting edge. It then steps falling edge by falling edge, compares every output against the phase number it computes itself, and checks the idle state and restored latch at the falling edge after T12.

// File: rtl/xdb_pkg.sv
package xdb_pkg;
   typedef logic [3:0] phase_t;

   localparam int unsigned CYC_LEN     = 12;
   localparam phase_t      PH_IDLE     = 4'd0;
   localparam phase_t      PH_FIRST    = 4'd1;
   localparam phase_t      PH_LAST     = 4'd12;
   localparam phase_t      PH_ALE_ON   = 4'd2;
   localparam phase_t      PH_ALE_OFF  = 4'd3;
   localparam phase_t      PH_ADR_ON   = 4'd3;
   localparam phase_t      PH_ADR_OFF  = 4'd5;
   localparam phase_t      PH_DAT_ON   = 4'd6;
   localparam phase_t      PH_STB_ON   = 4'd7;
   localparam phase_t      PH_STB_OFF  = 4'd11;
   localparam phase_t      PH_HI_ON    = 4'd3;

   typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;

   function automatic logic in_window(phase_t p, phase_t lo, phase_t hi);
      return (p >= lo) && (p <= hi);
   endfunction
endpackage

// File: rtl/xdb_sequencer.sv
module xdb_sequencer
   import xdb_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_wide,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DW-1:0]     req_wdata,
   output phase_t            phase,
   output logic              busy,
   output dir_e              cap_dir,
   output logic              cap_wide,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DW-1:0]     cap_wdata
);
   logic accept;

   assign busy   = (phase != PH_IDLE);
   assign accept = !busy && req_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else if (accept) begin
         phase <= PH_FIRST;
      end else if (phase == PH_LAST) begin
         phase <= PH_IDLE;
      end else if (busy) begin
         phase <= phase + 4'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_dir   <= DIR_RD;
         cap_wide  <= 1'b0;
         cap_addr  <= '0;
         cap_wdata <= '0;
      end else if (accept) begin
         cap_dir   <= req_write ? DIR_WR : DIR_RD;
         cap_wide  <= req_wide;
         cap_addr  <= req_addr;
         cap_wdata <= req_wdata;
      end
   end
endmodule

// File: rtl/xdb_lo_port.sv
module xdb_lo_port
   import xdb_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  phase_t        phase,
   input  dir_e          cap_dir,
   input  logic [DW-1:0] addr_lo,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] lo_port_in,
   output logic          ale,
   output logic          rd_n,
   output logic          wr_n,
   output logic [DW-1:0] lo_port_out,
   output logic          lo_port_oe,
   output logic [DW-1:0] rdata,
   output logic          rdata_valid
);
   localparam logic [DW-1:0] FLOAT_VAL = '1;

   logic adr_win, dat_win, stb_win, is_wr;

   assign is_wr   = (cap_dir == DIR_WR);
   assign adr_win = in_window(phase, PH_ADR_ON, PH_ADR_OFF);
   assign dat_win = is_wr && in_window(phase, PH_DAT_ON, PH_LAST);
   assign stb_win = in_window(phase, PH_STB_ON, PH_STB_OFF);

   always_comb begin
      ale         = in_window(phase, PH_ALE_ON, PH_ALE_OFF);
      rd_n        = !(stb_win && !is_wr);
      wr_n        = !(stb_win && is_wr);
      lo_port_oe  = adr_win || dat_win;
      if (adr_win)      lo_port_out = addr_lo;
      else if (dat_win) lo_port_out = wdata;
      else              lo_port_out = FLOAT_VAL;
      rdata_valid = (phase == PH_LAST) && !is_wr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if ((phase == PH_STB_OFF) && !is_wr) begin
         rdata <= lo_port_in;
      end
   end
endmodule

// File: rtl/xdb_hi_port.sv
module xdb_hi_port
   import xdb_pkg::*;
#(
   parameter int unsigned DW             = 8,
   parameter int unsigned STRONG_PERIODS = 2
) (
   input  phase_t        phase,
   input  logic          cap_wide,
   input  logic [DW-1:0] addr_hi,
   input  logic [DW-1:0] hi_latch,
   output logic [DW-1:0] hi_port_out,
   output logic          hi_strong
);
   logic override;

   assign override    = cap_wide && in_window(phase, PH_HI_ON, PH_LAST);
   assign hi_port_out = override ? addr_hi : hi_latch;

   generate
      if (STRONG_PERIODS == 0) begin : g_no_strong
         assign hi_strong = 1'b0;
      end else begin : g_strong
         localparam phase_t STRONG_END = phase_t'(PH_HI_ON + STRONG_PERIODS - 1);
         assign hi_strong = override && (phase <= STRONG_END);
      end
   endgenerate
endmodule

// File: rtl/xdata_bus_ctrl.sv
module xdata_bus_ctrl
   import xdb_pkg::*;
#(
   parameter int unsigned DW             = 8,
   parameter int unsigned STRONG_PERIODS = 2,
   localparam int unsigned ADDR_W        = 2 * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_wide,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic [DW-1:0]     hi_latch,
   input  logic [DW-1:0]     lo_port_in,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DW-1:0]     lo_port_out,
   output logic              lo_port_oe,
   output logic [DW-1:0]     hi_port_out,
   output logic              hi_strong,
   output logic              busy,
   output logic [DW-1:0]     rdata,
   output logic              rdata_valid
);
   generate
      if (DW < 1) begin : g_bad_dw
         initial $fatal(1, "DW must be at least 1");
      end
      if (STRONG_PERIODS > CYC_LEN - PH_HI_ON + 1) begin : g_bad_strong
         initial $fatal(1, "STRONG_PERIODS exceeds the override window");
      end
   endgenerate

   phase_t            phase;
   dir_e              cap_dir;
   logic              cap_wide;
   logic [ADDR_W-1:0] cap_addr;
   logic [DW-1:0]     cap_wdata;

   xdb_sequencer #(.ADDR_W(ADDR_W), .DW(DW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_wide  (req_wide),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .phase     (phase),
      .busy      (busy),
      .cap_dir   (cap_dir),
      .cap_wide  (cap_wide),
      .cap_addr  (cap_addr),
      .cap_wdata (cap_wdata)
   );

   xdb_lo_port #(.DW(DW)) u_lo (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase       (phase),
      .cap_dir     (cap_dir),
      .addr_lo     (cap_addr[DW-1:0]),
      .wdata       (cap_wdata),
      .lo_port_in  (lo_port_in),
      .ale         (ale),
      .rd_n        (rd_n),
      .wr_n        (wr_n),
      .lo_port_out (lo_port_out),
      .lo_port_oe  (lo_port_oe),
      .rdata       (rdata),
      .rdata_valid (rdata_valid)
   );

   xdb_hi_port #(.DW(DW), .STRONG_PERIODS(STRONG_PERIODS)) u_hi (
      .phase       (phase),
      .cap_wide    (cap_wide),
      .addr_hi     (cap_addr[ADDR_W-1:DW]),
      .hi_latch    (hi_latch),
      .hi_port_out (hi_port_out),
      .hi_strong   (hi_strong)
   );
endmodule

// File: rtl/xdb_checker.sv
module xdb_checker #(
   parameter int unsigned DW             = 8,
   parameter int unsigned STRONG_PERIODS = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_wide,
   input logic [DW-1:0] hi_latch,
   input logic          ale,
   input logic          rd_n,
   input logic          wr_n,
   input logic [DW-1:0] lo_port_out,
   input logic          lo_port_oe,
   input logic [DW-1:0] hi_port_out,
   input logic          hi_strong,
   input logic          busy
);
   logic [4:0] busy_cnt, ale_cnt, stb_cnt, strong_cnt;
   logic       seen_wide;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) begin
         busy_cnt   <= '0;
         ale_cnt    <= '0;
         stb_cnt    <= '0;
         strong_cnt <= '0;
      end else begin
         busy_cnt   <= busy_cnt + 5'd1;
         ale_cnt    <= ale_cnt + 5'(ale);
         stb_cnt    <= stb_cnt + 5'(!rd_n || !wr_n);
         strong_cnt <= strong_cnt + 5'(hi_strong);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  seen_wide <= 1'b0;
      else if (!busy && req_valid) seen_wide <= req_wide;
   end

   a_r1_twelve_periods: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_cnt == 5'd12);
   a_r2_single_ale: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ale_cnt == 5'd2);
   a_r2_idle_no_ale: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ale);
   a_r5_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> stb_cnt == 5'd5);
   a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   a_r4_read_port_released: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !lo_port_oe);
   a_r6_idle_float: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!lo_port_oe && lo_port_out == '1 && rd_n && wr_n));
   a_r7_restored: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (hi_port_out == hi_latch && !hi_strong));
   a_r8_narrow_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !seen_wide) |-> (hi_port_out == hi_latch && !hi_strong));
   a_r9_strong_count: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> strong_cnt == (seen_wide ? 5'(STRONG_PERIODS) : 5'd0));
endmodule

bind xdata_bus_ctrl xdb_checker #(.DW(DW), .STRONG_PERIODS(STRONG_PERIODS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_wide    (req_wide),
   .hi_latch    (hi_latch),
   .ale         (ale),
   .rd_n        (rd_n),
   .wr_n        (wr_n),
   .lo_port_out (lo_port_out),
   .lo_port_oe  (lo_port_oe),
   .hi_port_out (hi_port_out),
   .hi_strong   (hi_strong),
   .busy        (busy)
);

// File: tb/xdata_bus_ctrl_tb.sv
module xdata_bus_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_wide;
   logic [15:0] req_addr;
   logic [7:0]  req_wdata, hi_latch, lo_port_in;
   logic        ale, rd_n, wr_n, lo_port_oe, hi_strong, busy, rdata_valid;
   logic [7:0]  lo_port_out, hi_port_out, rdata;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xdata_bus_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
      .hi_latch(hi_latch), .lo_port_in(lo_port_in), .ale(ale), .rd_n(rd_n),
      .wr_n(wr_n), .lo_port_out(lo_port_out), .lo_port_oe(lo_port_oe),
      .hi_port_out(hi_port_out), .hi_strong(hi_strong), .busy(busy),
      .rdata(rdata), .rdata_valid(rdata_valid)
   );

   task automatic check(string tag, int t, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s at T%0d: actual %h expected %h", tag, t, act, exp);
      end
   endtask

   task automatic check_idle(string tag, logic [7:0] latch);
      check({tag, " R1 busy"}, 0, 16'(busy), 16'd0);
      check({tag, " R2 ale"}, 0, 16'(ale), 16'd0);
      check({tag, " R5 strobes"}, 0, 16'({rd_n, wr_n}), 16'd3);
      check({tag, " R6 oe"}, 0, 16'(lo_port_oe), 16'd0);
      check({tag, " R6 lo"}, 0, 16'(lo_port_out), 16'hFF);
      check({tag, " R7 hi"}, 0, 16'(hi_port_out), 16'(latch));
      check({tag, " R9 strong"}, 0, 16'(hi_strong), 16'd0);
   endtask

   // One full transfer; optional intruding request in T5 (R10), optional
   // hi_latch change at T6 (R8).
   task automatic run_access(bit w, bit wide, logic [15:0] addr, logic [7:0] wd,
                             logic [7:0] rd_in, bit intrude, bit move_latch);
      logic [7:0] latch;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_wide = wide;
      req_addr = addr; req_wdata = wd; lo_port_in = rd_in;
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 1; t <= 12; t++) begin
         if (intrude && t == 5) begin
            req_valid = 1'b1; req_write = !w; req_wide = !wide;
            req_addr = ~addr; req_wdata = ~wd;
         end
         if (intrude && t == 6) req_valid = 1'b0;
         if (move_latch && t == 6) hi_latch = hi_latch ^ 8'h5A;
         if (t == 12) lo_port_in = ~rd_in;
         #1;
         latch = hi_latch;
         check("R1 busy", t, 16'(busy), 16'd1);
         check("R2 ale", t, 16'(ale), 16'(t == 2 || t == 3));
         check("R3 oe", t, 16'(lo_port_oe),
               16'((t >= 3 && t <= 5) || (w && t >= 6)));
         check("R3 lo", t, 16'(lo_port_out),
               (t >= 3 && t <= 5) ? 16'(addr[7:0]) : ((w && t >= 6) ? 16'(wd) : 16'hFF));
         check("R4 rd_n", t, 16'(rd_n), 16'(!(!w && t >= 7 && t <= 11)));
         check("R5 wr_n", t, 16'(wr_n), 16'(!(w && t >= 7 && t <= 11)));
         check(wide ? "R7 hi" : "R8 hi", t, 16'(hi_port_out),
               (wide && t >= 3) ? 16'(addr[15:8]) : 16'(latch));
         check("R9 strong", t, 16'(hi_strong), 16'(wide && (t == 3 || t == 4)));
         check("R4 rdata_valid", t, 16'(rdata_valid), 16'(!w && t == 12));
         if (!w && t == 12) check("R4 rdata", t, 16'(rdata), 16'(rd_in));
         @(negedge clk);
      end
      check_idle(intrude ? "R10 after" : "post", hi_latch);
      if (!w) check("R4 rdata held", 13, 16'(rdata), 16'(rd_in));
      if (intrude) begin
         @(negedge clk);
         check_idle("R10 no second transfer", hi_latch);
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
      req_addr = '0; req_wdata = '0; hi_latch = 8'h3C; lo_port_in = 8'h00;
      repeat (3) @(negedge clk);
      check_idle("reset", hi_latch);
      check("R4 reset rdata", 0, 16'(rdata), 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_wide_read;   run_access(1'b0, 1'b1, 16'hA512, 8'h00, 8'hC3, 1'b0, 1'b0); endtask
   task automatic t_wide_write;  run_access(1'b1, 1'b1, 16'h7E01, 8'h96, 8'h11, 1'b0, 1'b0); endtask
   task automatic t_narrow_read; run_access(1'b0, 1'b0, 16'hFF80, 8'h00, 8'h4D, 1'b0, 1'b1); endtask
   task automatic t_narrow_write;run_access(1'b1, 1'b0, 16'h00FE, 8'h00, 8'h00, 1'b0, 1'b1); endtask
   task automatic t_intrude;     run_access(1'b0, 1'b1, 16'h0000, 8'h00, 8'hFF, 1'b1, 1'b0); endtask
   task automatic t_back_to_back;
      run_access(1'b1, 1'b1, 16'hFFFF, 8'h01, 8'h00, 1'b0, 1'b0);
      run_access(1'b0, 1'b0, 16'h1234, 8'h00, 8'h80, 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_wide_read();
      t_wide_write();
      t_narrow_read();
      t_narrow_write();
      t_intrude();
      t_back_to_back();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule